// File: doc/BRIEF.md
# EEPROM Page Write-Protection Controller

This controller sits between a CPU bus and a small on-chip EEPROM store. It guards every byte write and byte erase with a per-page protect bit and a two-bit arming field. A single mode bit picks which area an access lands in. With the mode bit at 1, accesses reach the byte data area. With it at 0, the first byte address of each page instead reaches that page's protect bit.

Software protects a page in three steps. It clears the mode bit, which also disarms the arming field. It re-arms the field. It then writes or erases at the page's first address. When that operation finishes, hardware puts the mode bit back to 1 on its own. Each accepted operation keeps the controller busy for a fixed, parameterised number of cycles. Reads are 16 bits wide and are aligned to the even byte address.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the mode register reads 0xFF and the arming register reads 0xFF. All protect bits are clear, every storage byte is 0xFF, and busy and reject are low.
- R2: Mode register (reg_sel=0): bit 7 is the mode bit (1 = data area, 0 = protect area). Bits 6..0 always read 1 and ignore writes.
- R3: Every write to the mode register forces the arming field (bits 1..0 of the arming register, reg_sel=1) to 2'b11. Bits 7..2 of the arming register read 1.
- R4: While the arming field is 2'b11, a write or erase is rejected and storage is left unchanged.
- R5: In the data area, a write stores mem_wdata in the addressed byte and an erase sets it to 0xFF. Either one is rejected if the page's protect bit is set.
- R6: In the protect area, a write at a page's first address sets that page's protect bit to mem_wdata[0], and an erase clears it. A write or erase at any other address is ignored: there is no reject, no busy and no change.
- R7: A read in the protect area returns 0xFFFE ORed with the protect bit of the page that holds the address.
- R8: A read in the data area returns the byte at the even address in bits 7..0 and the next byte in bits 15..8. An odd address reads the same word as the even address below it. mem_rdata is valid the cycle after mem_rd.
- R9: An accepted operation holds busy high for exactly OP_CYCLES cycles, starting the cycle after the request. Any write or erase requested while busy is rejected.
- R10: When an operation in the protect area completes, the mode bit returns to 1. A mode-register write in the same cycle takes precedence.
- R11: sleep_req restores both registers to their reset values. Protect bits and storage are kept.
- R12: reject is high for exactly one cycle, the cycle after each rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Restores both registers to reset values |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = mode register, 1 = arming register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register, combinational |
| mem_rd | input | 1 | Word read request |
| mem_wr | input | 1 | Byte write request |
| mem_erase | input | 1 | Byte erase request (takes priority over write) |
| mem_addr | input | 8 | Byte address (default geometry) |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 16 | Registered read data |
| busy | output | 1 | Operation in progress |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
Two events can meet in one cycle: the completion of a protect-area operation, which sets the mode bit, and a software write of 0 to the mode register. The bench starts a protect-bit write and counts the cycles of the busy window. It then issues the register write so that it lands on the exact edge where busy falls. It expects the mode bit to stay 0, the arming field to read 2'b11, and the new protect bit to be stored.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

    typedef enum logic {
        AREA_PROT = 1'b0,
        AREA_DATA = 1'b1
    } area_e;

    typedef enum logic {
        SEL_MODE = 1'b0,
        SEL_ARM  = 1'b1
    } regsel_e;

    typedef enum logic [1:0] {
        VD_NONE,
        VD_ACCEPT,
        VD_REJECT,
        VD_IGNORE
    } verdict_e;

    typedef struct packed {
        logic erase;
        logic prot_area;
    } op_kind_t;

    localparam logic [1:0] ARM_OFF = 2'b11;

    function automatic logic is_disarmed(input logic [1:0] arm);
        return arm == ARM_OFF;
    endfunction

endpackage

// File: rtl/eg_regs.sv
module eg_regs
    import eeprom_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       op_done,
    input  logic       done_prot,
    output area_e      mode,
    output logic [1:0] arm,
    output logic [7:0] reg_rdata
);

    always_ff @(posedge clk) begin
        if (rst || sleep_req) begin
            mode <= AREA_DATA;
            arm  <= ARM_OFF;
        end else if (reg_wr && regsel_e'(reg_sel) == SEL_MODE) begin
            // a mode write always disarms and wins over completion
            mode <= area_e'(reg_wdata[7]);
            arm  <= ARM_OFF;
        end else begin
            if (reg_wr && regsel_e'(reg_sel) == SEL_ARM)
                arm <= reg_wdata[1:0];
            if (op_done && done_prot)
                mode <= AREA_DATA;
        end
    end

    always_comb begin
        if (regsel_e'(reg_sel) == SEL_MODE)
            reg_rdata = {mode, 7'h7F};
        else
            reg_rdata = {6'h3F, arm};
    end

endmodule

// File: rtl/eg_gate.sv
module eg_gate
    import eeprom_guard_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 8,
    parameter int OP_CYCLES  = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                mem_wr,
    input  logic                                mem_erase,
    input  logic [$clog2(PAGE_BYTES*PAGES)-1:0] mem_addr,
    input  area_e                               mode,
    input  logic [1:0]                          arm,
    input  logic                                page_prot,
    output logic                                accept,
    output op_kind_t                            kind,
    output logic                                busy,
    output logic                                op_done,
    output logic                                done_prot,
    output logic                                reject
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             prot_q;
    verdict_e         verdict;
    logic             page_start;

    assign page_start = (mem_addr[OFF_W-1:0] == '0);
    assign busy       = (cnt_q != '0);
    assign op_done    = (cnt_q == CNT_W'(1));
    assign done_prot  = prot_q;

    always_comb begin
        if (!(mem_wr || mem_erase))
            verdict = VD_NONE;
        else if (busy)
            verdict = VD_REJECT;
        else if (mode == AREA_PROT && !page_start)
            verdict = VD_IGNORE;
        else if (is_disarmed(arm))
            verdict = VD_REJECT;
        else if (mode == AREA_DATA && page_prot)
            verdict = VD_REJECT;
        else
            verdict = VD_ACCEPT;
    end

    assign accept         = (verdict == VD_ACCEPT);
    assign kind.erase     = mem_erase;
    assign kind.prot_area = (mode == AREA_PROT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prot_q <= 1'b0;
            reject <= 1'b0;
        end else begin
            reject <= (verdict == VD_REJECT);
            if (accept) begin
                cnt_q  <= CNT_LOAD;
                prot_q <= kind.prot_area;
            end else if (busy) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/eg_store.sv
module eg_store
    import eeprom_guard_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                accept,
    input  op_kind_t                            kind,
    input  logic [$clog2(PAGE_BYTES*PAGES)-1:0] mem_addr,
    input  logic [7:0]                          mem_wdata,
    input  logic                                mem_rd,
    input  area_e                               mode,
    output logic                                page_prot,
    output logic [15:0]                         mem_rdata
);

    localparam int DEPTH  = PAGE_BYTES * PAGES;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1;

    logic [7:0]       cells [DEPTH];
    logic [PAGES-1:0] prot_q;
    logic [PG_W-1:0]  page;
    logic [ADDR_W-1:0] even_a, odd_a;

    assign page      = PG_W'(mem_addr >> OFF_W);
    assign page_prot = prot_q[page];
    assign even_a    = {mem_addr[ADDR_W-1:1], 1'b0};
    assign odd_a     = {mem_addr[ADDR_W-1:1], 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
        end else if (accept && kind.prot_area) begin
            prot_q[page] <= kind.erase ? 1'b0 : mem_wdata[0];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= 8'hFF;
            else if (accept && !kind.prot_area && mem_addr == ADDR_W'(i))
                cells[i] <= kind.erase ? 8'hFF : mem_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mem_rdata <= 16'hFFFF;
        else if (mem_rd) begin
            if (mode == AREA_PROT)
                mem_rdata <= {15'h7FFF, page_prot};
            else
                mem_rdata <= {cells[odd_a], cells[even_a]};
        end
    end

endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
    import eeprom_guard_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 8,
    parameter int OP_CYCLES  = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                sleep_req,
    input  logic                                reg_wr,
    input  logic                                reg_sel,
    input  logic [7:0]                          reg_wdata,
    output logic [7:0]                          reg_rdata,
    input  logic                                mem_rd,
    input  logic                                mem_wr,
    input  logic                                mem_erase,
    input  logic [$clog2(PAGE_BYTES*PAGES)-1:0] mem_addr,
    input  logic [7:0]                          mem_wdata,
    output logic [15:0]                         mem_rdata,
    output logic                                busy,
    output logic                                reject
);

    area_e      mode_q;
    logic       mode_bit;
    logic [1:0] ctl_bits;
    logic       op_done;
    logic       done_prot;
    logic       accept;
    logic       page_prot;
    op_kind_t   kind;

    assign mode_bit = mode_q;

    eg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .op_done   (op_done),
        .done_prot (done_prot),
        .mode      (mode_q),
        .arm       (ctl_bits),
        .reg_rdata (reg_rdata)
    );

    eg_gate #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGES      (PAGES),
        .OP_CYCLES  (OP_CYCLES)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .mem_wr    (mem_wr),
        .mem_erase (mem_erase),
        .mem_addr  (mem_addr),
        .mode      (mode_q),
        .arm       (ctl_bits),
        .page_prot (page_prot),
        .accept    (accept),
        .kind      (kind),
        .busy      (busy),
        .op_done   (op_done),
        .done_prot (done_prot),
        .reject    (reject)
    );

    eg_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGES      (PAGES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .kind      (kind),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mode      (mode_q),
        .page_prot (page_prot),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/eg_checker.sv
module eg_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] reg_rdata,
    input logic       mem_wr,
    input logic       mem_erase,
    input logic       busy,
    input logic       reject,
    input logic       mode_bit,
    input logic [1:0] ctl_bits,
    input logic       op_done,
    input logic       done_prot
);

    AST_RSV_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> reg_rdata[6:0] == 7'h7F);                                     // R2

    AST_MODE_WR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !reg_sel |=> ctl_bits == 2'b11);                                 // R3

    AST_DISARMED_REJECT: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || mem_erase) && !busy && mode_bit && ctl_bits == 2'b11 |=> reject); // R4

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy && (mem_wr || mem_erase) |=> reject);                                 // R9

    AST_REJECT_NOT_START: assert property (@(posedge clk) disable iff (rst)
        reject |-> !$rose(busy));                                                  // R9

    AST_DONE_RETURNS_DATA: assert property (@(posedge clk) disable iff (rst)
        op_done && done_prot && !(reg_wr && !reg_sel) |=> mode_bit);               // R10

    AST_SLEEP_RESTORES: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> mode_bit && ctl_bits == 2'b11);                              // R11

    AST_REJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reject |-> $past(mem_wr || mem_erase));                                    // R12

endmodule

bind eeprom_guard eg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .mem_wr    (mem_wr),
    .mem_erase (mem_erase),
    .busy      (busy),
    .reject    (reject),
    .mode_bit  (mode_bit),
    .ctl_bits  (ctl_bits),
    .op_done   (op_done),
    .done_prot (done_prot)
);

// File: tb/eeprom_guard_tb_top.sv
module eeprom_guard_tb_top;

    localparam int OPC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        mem_erase = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [15:0] mem_rdata;
    logic        busy;
    logic        reject;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    eeprom_guard #(.PAGE_BYTES(32), .PAGES(8), .OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_erase(mem_erase), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .reject(reject)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic mem_op(input logic er, input logic [7:0] a, input logic [7:0] d,
                          output logic rej, output logic bsy);
        @(negedge clk);
        mem_wr = ~er; mem_erase = er; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0; mem_erase = 1'b0;
        rej = reject; bsy = busy;
    endtask

    task automatic mem_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        mem_rd = 1'b1; mem_addr = a;
        @(negedge clk);
        mem_rd = 1'b0;
        d = mem_rdata;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r; logic [15:0] w;
        reg_read(1'b0, r); check("R1 mode reg", r, 8'hFF);
        reg_read(1'b1, r); check("R1 arm reg", r, 8'hFF);
        check("R1 busy", busy, 0);
        check("R1 reject", reject, 0);
        mem_read(8'd0, w); check("R1 storage", w, 16'hFFFF);
    endtask

    task automatic t_regs();
        logic [7:0] r;
        reg_write(1'b0, 8'h00); reg_read(1'b0, r); check("R2 reserved ones", r, 8'h7F);
        reg_write(1'b1, 8'h00); reg_read(1'b1, r); check("R3 arm write", r, 8'hFC);
        reg_write(1'b0, 8'h80); reg_read(1'b0, r); check("R2 mode set", r, 8'hFF);
        reg_read(1'b1, r); check("R3 disarmed by mode write", r, 8'hFF);
    endtask

    task automatic t_disarmed();
        logic rj, bs; logic [15:0] w;
        mem_op(1'b0, 8'd4, 8'h55, rj, bs);
        check("R4 reject", rj, 1); check("R4 no busy", bs, 0);
        @(negedge clk); check("R12 single pulse", reject, 0);
        mem_read(8'd4, w); check("R4 unchanged", w, 16'hFFFF);
    endtask

    task automatic t_data();
        logic rj, bs; logic [15:0] w; int n;
        reg_write(1'b1, 8'h00);
        mem_op(1'b0, 8'd4, 8'h12, rj, bs);
        check("R5 accept", rj, 0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 busy length", n, OPC);
        mem_op(1'b0, 8'd5, 8'h34, rj, bs); wait_idle();
        mem_read(8'd5, w); check("R8 odd aligned", w, 16'h3412);
        mem_read(8'd4, w); check("R8 even word", w, 16'h3412);
        mem_op(1'b1, 8'd5, 8'h00, rj, bs); wait_idle();
        mem_read(8'd4, w); check("R5 erase", w, 16'hFF12);
    endtask

    task automatic t_busy();
        logic rj, bs; logic [15:0] w;
        mem_op(1'b0, 8'd10, 8'h01, rj, bs);
        mem_op(1'b0, 8'd11, 8'h77, rj, bs);
        check("R9 reject while busy", rj, 1);
        wait_idle();
        mem_read(8'd10, w); check("R9 blocked write absent", w, 16'hFF01);
    endtask

    task automatic t_protect();
        logic rj, bs; logic [7:0] r; logic [15:0] w;
        reg_write(1'b0, 8'h00); reg_write(1'b1, 8'h00);
        mem_op(1'b0, 8'd64, 8'h01, rj, bs); check("R6 protect accept", rj, 0);
        wait_idle();
        reg_read(1'b0, r); check("R10 back to data", r, 8'hFF);
        mem_op(1'b0, 8'd70, 8'hAA, rj, bs); check("R5 protected reject", rj, 1);
        mem_read(8'd70, w); check("R5 protected unchanged", w, 16'hFFFF);
        reg_write(1'b0, 8'h00); reg_write(1'b1, 8'h00);
        mem_op(1'b0, 8'd65, 8'h00, rj, bs);
        check("R6 ignored no reject", rj, 0); check("R6 ignored no busy", bs, 0);
        mem_read(8'd70, w); check("R7 bit set", w, 16'hFFFF);
        mem_read(8'd96, w); check("R7 bit clear", w, 16'hFFFE);
        mem_op(1'b1, 8'd64, 8'h00, rj, bs); check("R6 erase accept", rj, 0);
        wait_idle();
        mem_op(1'b0, 8'd70, 8'hAA, rj, bs); check("R6 unprotected", rj, 0);
        wait_idle();
        mem_read(8'd70, w); check("R6 data after unprotect", w, 16'hFFAA);
    endtask

    task automatic t_collision();
        logic rj, bs; logic [7:0] r; logic [15:0] w;
        reg_write(1'b0, 8'h00); reg_write(1'b1, 8'h00);
        mem_op(1'b0, 8'd32, 8'h01, rj, bs);
        repeat (OPC - 2) @(negedge clk);
        reg_write(1'b0, 8'h00);
        check("R10 busy ended", busy, 0);
        reg_read(1'b0, r); check("R10 software write wins", r, 8'h7F);
        reg_read(1'b1, r); check("R3 disarmed at collision", r, 8'hFF);
        mem_read(8'd32, w); check("R6 collision bit stored", w, 16'hFFFF);
        reg_write(1'b0, 8'h80);
    endtask

    task automatic t_sleep();
        logic rj, bs; logic [7:0] r; logic [15:0] w;
        reg_write(1'b0, 8'h00); reg_write(1'b1, 8'h01);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        reg_read(1'b0, r); check("R11 mode reg", r, 8'hFF);
        reg_read(1'b1, r); check("R11 arm reg", r, 8'hFF);
        reg_write(1'b1, 8'h00);
        mem_op(1'b0, 8'd40, 8'h00, rj, bs); check("R11 protect kept", rj, 1);
        mem_read(8'd4, w); check("R11 storage kept", w, 16'hFF12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_disarmed();
        t_data();
        t_busy();
        t_protect();
        t_collision();
        t_sleep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1-flow act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule